// File: doc/BRIEF.md
# Range-Matched Translation Buffer with Pinned Slots

This block is a small, fully associative translation buffer. Each slot holds an inclusive virtual range (first and last byte address), a physical base, a protection word and a valid flag. A registered lookup port returns whether the address translates, the winning slot and the translated physical address. When several ranges contain the address, the lowest-numbered slot decides the result.

The slots are split into two groups. The low `PINNED` slots hold block mappings that may span many pages. They are loaded and cleared only by their own forced commands. The remaining ordinary slots each map one page. They are filled by a two-step sequence: a map command places the address range and physical page, and a protection command then arms the entry. When every ordinary slot is in use, a round-robin pointer picks the slot to replace. Page purges and the bulk purge touch only ordinary slots.

Commands are single-cycle and take effect at the clock edge that samples them. A lookup presented in the same cycle still sees the table as it was before that command.

Top module: `range_xlat_buf`

## Requirements
- R1: After reset every slot is cleared, `lk_hit` is 0, `cmd_err` is 0 and the round-robin pointer holds `PINNED`.
- R2: For a lookup, a slot contains the address when first <= address <= last. The lowest-indexed slot that contains it decides the result, which is a hit only if that slot is valid. `lk_hit`, `lk_slot`, `lk_pa` and `lk_prot` appear one cycle after `lk_va`, and are all zero on a miss.
- R3: On a hit, `lk_pa` equals the slot's physical base plus (address minus range first), and `lk_prot` is the slot's protection word.
- R4: Map (op 1) sets first to `cmd_va` with the low `PG_BITS` cleared and last to first + 2^PG_BITS - 1. It sets the physical base to `cmd_data[PPN_LSB+PPN_W-1:PPN_LSB]` shifted left by `PG_BITS` and leaves the entry invalid. In the same cycle, every valid ordinary slot containing `cmd_va` is cleared.
- R5: Map writes the highest-indexed ordinary slot that is either invalid or contains `cmd_va`.
- R6: If no ordinary slot qualifies, map uses the pointer. When the pointer is below `PINNED` or at least `SLOTS`, it writes slot `PINNED` and sets the pointer to `PINNED`+1. Otherwise it writes the pointer's slot and increments the pointer.
- R7: Protect (op 2) writes `cmd_data` into the protection word of the lowest-indexed slot containing `cmd_va`, pinned or ordinary, and makes it valid. If no slot contains `cmd_va`, nothing changes and `cmd_err` is 1 in the next cycle.
- R8: Purge page (op 3) clears the lowest-indexed slot containing `cmd_va`, but only if it is valid and ordinary. A pinned slot stays intact.
- R9: Purge ordinary (op 4) clears all ordinary slots, keeps pinned slots and resets the pointer to `PINNED`.
- R10: Pin load (op 5) clears slot `cmd_slot`, then sets first to the page-aligned `cmd_va` and last to first + `cmd_len`*2^PG_BITS - 1. The physical base is taken from the same data field as map, and the slot is left invalid. If `cmd_slot` >= `PINNED` or `cmd_len` is 0, nothing changes and `cmd_err` is 1 in the next cycle.
- R11: Pin clear (op 6) clears slot `cmd_slot`, and raises `cmd_err` instead if `cmd_slot` >= `PINNED`. Pin clear all (op 7) clears every pinned slot. Op 0 does nothing.
- R12: A cleared slot has first all ones and last zero, and it matches no address, including all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Registered: lookup translated |
| lk_slot | output | $clog2(SLOTS) | Registered: winning slot |
| lk_pa | output | PA_W | Registered: physical address |
| lk_prot | output | PROT_W | Registered: protection word of winning slot |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (see R4 to R11) |
| cmd_va | input | VA_W | Command virtual address |
| cmd_data | input | DATA_W | Physical page field or protection word |
| cmd_len | input | LEN_W | Pin load length in pages |
| cmd_slot | input | $clog2(SLOTS) | Pinned slot for pin commands |
| cmd_err | output | 1 | Registered: previous command was rejected |

## Verification
The hardest state to reach is the round-robin pointer running past the last slot and wrapping back to slot `PINNED`. Reaching it takes a full ordinary partition of armed entries, because a map that is never protected leaves an invalid slot that the next map reuses. The bench first resets the pointer with a bulk purge. It then arms one page in each ordinary slot and performs seven more map-and-protect pairs, so the pointer walks every ordinary slot and wraps once. A shadowing case is also built on purpose: a pinned block over an already mapped page, which must win the lookup and survive a page purge.

// File: rtl/range_xlat_buf.sv
module range_xlat_buf #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int DATA_W  = 32,
  parameter int PROT_W  = 32,
  parameter int SLOTS   = 8,
  parameter int PINNED  = 2,
  parameter int PG_BITS = 12,
  parameter int PPN_LSB = 5,
  parameter int PPN_W   = 20,
  parameter int LEN_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [VA_W-1:0]            lk_va,
  output logic                       lk_hit,
  output logic [$clog2(SLOTS)-1:0]   lk_slot,
  output logic [PA_W-1:0]            lk_pa,
  output logic [PROT_W-1:0]          lk_prot,
  input  logic                       cmd_valid,
  input  logic [2:0]                 cmd_op,
  input  logic [VA_W-1:0]            cmd_va,
  input  logic [DATA_W-1:0]          cmd_data,
  input  logic [LEN_W-1:0]           cmd_len,
  input  logic [$clog2(SLOTS)-1:0]   cmd_slot,
  output logic                       cmd_err
);
  localparam int IW = $clog2(SLOTS);
  localparam int PW = $clog2(SLOTS + 1);
  localparam logic [2:0] OP_MAP = 3'd1, OP_PROT = 3'd2, OP_PURGE = 3'd3,
                         OP_PURGE_ORD = 3'd4, OP_PIN = 3'd5, OP_PIN_CLR = 3'd6,
                         OP_PIN_CLR_ALL = 3'd7;

  logic [VA_W-1:0]   first_q [SLOTS];
  logic [VA_W-1:0]   last_q  [SLOTS];
  logic [PA_W-1:0]   base_q  [SLOTS];
  logic [PROT_W-1:0] prot_q  [SLOTS];
  logic [SLOTS-1:0]  vld_q;
  logic [PW-1:0]     rr_q;

  logic [SLOTS-1:0] cov_l, cov_c;

  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign cov_l[g] = (first_q[g] <= lk_va)  && (lk_va  <= last_q[g]);
    assign cov_c[g] = (first_q[g] <= cmd_va) && (cmd_va <= last_q[g]);
  end

  function automatic logic [IW:0] lowest(input logic [SLOTS-1:0] v);
    lowest = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (v[i]) lowest = {1'b1, IW'(i)};
  endfunction

  wire [IW:0]   l_sel = lowest(cov_l);
  wire [IW:0]   c_sel = lowest(cov_c);
  wire [IW-1:0] l_idx = l_sel[IW-1:0];
  wire [IW-1:0] c_idx = c_sel[IW-1:0];
  wire          l_hit = l_sel[IW] && vld_q[l_idx];

  wire [VA_W-1:0] pg_first = {cmd_va[VA_W-1:PG_BITS], {PG_BITS{1'b0}}};
  wire [PA_W-1:0] pg_base  = PA_W'(cmd_data[PPN_LSB +: PPN_W]) << PG_BITS;
  wire [VA_W-1:0] pg_last  = pg_first + ((VA_W'(1) << PG_BITS) - VA_W'(1));
  wire [VA_W-1:0] pin_last = pg_first + (VA_W'(cmd_len) << PG_BITS) - VA_W'(1);
  wire            slot_ok  = cmd_slot < IW'(PINNED);

  logic          emp_any;
  logic [IW-1:0] emp_idx, tgt;
  logic [PW-1:0] rr_nxt;

  always_comb begin
    emp_any = 1'b0;
    emp_idx = '0;
    for (int i = PINNED; i < SLOTS; i++)
      if (!vld_q[i] || cov_c[i]) begin
        emp_any = 1'b1;
        emp_idx = IW'(i);
      end
    if (rr_q < PW'(PINNED) || rr_q >= PW'(SLOTS)) begin
      rr_nxt = PW'(PINNED + 1);
      tgt    = IW'(PINNED);
    end else begin
      rr_nxt = rr_q + PW'(1);
      tgt    = IW'(rr_q);
    end
    if (emp_any) tgt = emp_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        first_q[i] <= '1;
        last_q[i]  <= '0;
        base_q[i]  <= '0;
        prot_q[i]  <= '0;
      end
      vld_q   <= '0;
      rr_q    <= PW'(PINNED);
      lk_hit  <= 1'b0;
      lk_slot <= '0;
      lk_pa   <= '0;
      lk_prot <= '0;
      cmd_err <= 1'b0;
    end else begin
      lk_hit  <= l_hit;
      lk_slot <= l_hit ? l_idx : '0;
      lk_pa   <= l_hit ? base_q[l_idx] + PA_W'(lk_va - first_q[l_idx]) : '0;
      lk_prot <= l_hit ? prot_q[l_idx] : '0;
      cmd_err <= 1'b0;
      if (cmd_valid) begin
        case (cmd_op)
          OP_MAP: begin
            for (int i = PINNED; i < SLOTS; i++)
              if (cov_c[i] && vld_q[i]) begin
                first_q[i] <= '1;
                last_q[i]  <= '0;
                base_q[i]  <= '0;
                prot_q[i]  <= '0;
                vld_q[i]   <= 1'b0;
              end
            first_q[tgt] <= pg_first;
            last_q[tgt]  <= pg_last;
            base_q[tgt]  <= pg_base;
            prot_q[tgt]  <= '0;
            vld_q[tgt]   <= 1'b0;
            if (!emp_any) rr_q <= rr_nxt;
          end
          OP_PROT: begin
            if (c_sel[IW]) begin
              prot_q[c_idx] <= cmd_data[PROT_W-1:0];
              vld_q[c_idx]  <= 1'b1;
            end else begin
              cmd_err <= 1'b1;
            end
          end
          OP_PURGE: begin
            if (c_sel[IW] && vld_q[c_idx] && c_idx >= IW'(PINNED)) begin
              first_q[c_idx] <= '1;
              last_q[c_idx]  <= '0;
              base_q[c_idx]  <= '0;
              prot_q[c_idx]  <= '0;
              vld_q[c_idx]   <= 1'b0;
            end
          end
          OP_PURGE_ORD: begin
            for (int i = PINNED; i < SLOTS; i++) begin
              first_q[i] <= '1;
              last_q[i]  <= '0;
              base_q[i]  <= '0;
              prot_q[i]  <= '0;
              vld_q[i]   <= 1'b0;
            end
            rr_q <= PW'(PINNED);
          end
          OP_PIN: begin
            if (slot_ok && cmd_len != '0) begin
              first_q[cmd_slot] <= pg_first;
              last_q[cmd_slot]  <= pin_last;
              base_q[cmd_slot]  <= pg_base;
              prot_q[cmd_slot]  <= '0;
              vld_q[cmd_slot]   <= 1'b0;
            end else begin
              cmd_err <= 1'b1;
            end
          end
          OP_PIN_CLR: begin
            if (slot_ok) begin
              first_q[cmd_slot] <= '1;
              last_q[cmd_slot]  <= '0;
              base_q[cmd_slot]  <= '0;
              prot_q[cmd_slot]  <= '0;
              vld_q[cmd_slot]   <= 1'b0;
            end else begin
              cmd_err <= 1'b1;
            end
          end
          OP_PIN_CLR_ALL: begin
            for (int i = 0; i < PINNED; i++) begin
              first_q[i] <= '1;
              last_q[i]  <= '0;
              base_q[i]  <= '0;
              prot_q[i]  <= '0;
              vld_q[i]   <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module range_xlat_buf_chk #(
  parameter int VA_W    = 32,
  parameter int SLOTS   = 8,
  parameter int PINNED  = 2,
  parameter int PG_BITS = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [VA_W-1:0]          lk_va,
  input logic                     lk_hit,
  input logic [$clog2(SLOTS)-1:0] lk_slot,
  input logic [PG_BITS-1:0]       pa_low,
  input logic                     cmd_valid,
  input logic [2:0]               cmd_op,
  input logic [VA_W-1:0]          cmd_va,
  input logic                     cmd_err
);
  localparam int IW = $clog2(SLOTS);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!lk_hit && !cmd_err));

  // R7 R10 R11
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd5 || cmd_op == 3'd6)));

  // R3
  pa_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (pa_low == $past(lk_va[PG_BITS-1:0])));

  // R9
  purge_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_valid && cmd_op == 3'd4, 2) |-> !(lk_hit && lk_slot >= IW'(PINNED)));

  // R8
  purge_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_valid && cmd_op == 3'd3, 2) &&
     ($past(lk_va, 1) >> PG_BITS) == ($past(cmd_va, 2) >> PG_BITS))
    |-> !(lk_hit && lk_slot >= IW'(PINNED)));
endmodule

bind range_xlat_buf range_xlat_buf_chk #(
  .VA_W(VA_W), .SLOTS(SLOTS), .PINNED(PINNED), .PG_BITS(PG_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit), .lk_slot(lk_slot),
  .pa_low(lk_pa[PG_BITS-1:0]), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_va(cmd_va), .cmd_err(cmd_err)
);

// File: tb/test_range_xlat_buf.sv
`timescale 1ns/1ps
module test_range_xlat_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_hit;
  logic [2:0]  lk_slot;
  logic [31:0] lk_pa;
  logic [31:0] lk_prot;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_va = '0;
  logic [31:0] cmd_data = '0;
  logic [7:0]  cmd_len = '0;
  logic [2:0]  cmd_slot = '0;
  logic        cmd_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  range_xlat_buf i_range_xlat_buf (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit), .lk_slot(lk_slot),
    .lk_pa(lk_pa), .lk_prot(lk_prot), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_va(cmd_va), .cmd_data(cmd_data), .cmd_len(cmd_len), .cmd_slot(cmd_slot),
    .cmd_err(cmd_err)
  );

  typedef struct {
    bit          is_err;
    bit          hit;
    logic [2:0]  slot;
    logic [31:0] pa;
    logic [31:0] prot;
    string       tag;
  } exp_t;
  exp_t q[$];

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (e.is_err) begin
        if (cmd_err !== e.hit) begin
          n_bad++;
          $display("FAIL %s: cmd_err=%0b expected %0b", e.tag, cmd_err, e.hit);
        end
      end else if (!e.hit) begin
        if (lk_hit !== 1'b0) begin
          n_bad++;
          $display("FAIL %s: lk_hit=%0b slot=%0d expected miss", e.tag, lk_hit, lk_slot);
        end
      end else if (lk_hit !== 1'b1 || lk_slot !== e.slot || lk_pa !== e.pa || lk_prot !== e.prot) begin
        n_bad++;
        $display("FAIL %s: hit=%0b slot=%0d pa=%h prot=%h expected hit slot=%0d pa=%h prot=%h",
                 e.tag, lk_hit, lk_slot, lk_pa, lk_prot, e.slot, e.pa, e.prot);
      end
    end
  end

  task automatic look(input logic [31:0] va, input bit h, input int sl,
                      input logic [31:0] pa, input logic [31:0] pr, input string tag);
    exp_t e;
    @(negedge clk);
    cmd_valid = 1'b0;
    lk_va = va;
    @(posedge clk);
    #1;
    e.is_err = 1'b0; e.hit = h; e.slot = 3'(sl); e.pa = pa; e.prot = pr; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [31:0] va, input logic [31:0] data,
                     input int len, input int sl, input bit er, input string tag);
    exp_t e;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_va = va; cmd_data = data;
    cmd_len = 8'(len); cmd_slot = 3'(sl);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    e.is_err = 1'b1; e.hit = er; e.slot = '0; e.pa = '0; e.prot = '0; e.tag = tag;
    q.push_back(e);
  endtask

  function automatic logic [31:0] ppn_of(input logic [31:0] va);
    return (va >> 12) + 32'h100;
  endfunction

  task automatic page(input logic [31:0] va, input logic [31:0] pr, input string tag);
    cmd(3'd1, va, ppn_of(va) << 5, 0, 0, 1'b0, tag);
    cmd(3'd2, va, pr, 0, 0, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R12: empty table after reset
    look(32'h0000_1234, 0, 0, 0, 0, "R1 reset miss");
    look(32'hFFFF_FFFF, 0, 0, 0, 0, "R12 all-ones miss");
    // R4: map leaves entry invalid
    cmd(3'd1, 32'h0001_2345, 32'hABCDE << 5, 0, 0, 1'b0, "R4 map");
    look(32'h0001_2345, 0, 0, 0, 0, "R4 invalid after map");
    // R7: protect arms the entry; R5 places it in slot 7
    cmd(3'd2, 32'h0001_2FFF, 32'h5A5A, 0, 0, 1'b0, "R7 protect");
    look(32'h0001_2345, 1, 7, 32'hABCD_E345, 32'h5A5A, "R3 R5 hit slot7");
    look(32'h0001_2FFF, 1, 7, 32'hABCD_EFFF, 32'h5A5A, "R2 last byte inclusive");
    look(32'h0001_3000, 0, 0, 0, 0, "R2 past last");
    look(32'h0001_1FFF, 0, 0, 0, 0, "R2 before first");
    cmd(3'd2, 32'h0009_9000, 32'h1, 0, 0, 1'b1, "R7 protect miss error");
    // R5: fill highest empty first
    page(32'h0002_0000, 32'h1, "R5 fill");
    page(32'h0003_0000, 32'h1, "R5 fill");
    page(32'h0004_0000, 32'h1, "R5 fill");
    page(32'h0005_0000, 32'h1, "R5 fill");
    page(32'h0006_0000, 32'h1, "R5 fill");
    look(32'h0002_0010, 1, 6, 32'h0012_0010, 32'h1, "R5 slot6");
    look(32'h0006_0010, 1, 2, 32'h0016_0010, 32'h1, "R5 slot2");
    // R6: evictions from pointer
    cmd(3'd1, 32'h0007_0000, ppn_of(32'h0007_0000) << 5, 0, 0, 1'b0, "R6 evict");
    look(32'h0006_0000, 0, 0, 0, 0, "R6 slot2 victim");
    cmd(3'd2, 32'h0007_0000, 32'h2, 0, 0, 1'b0, "R6 protect");
    look(32'h0007_0123, 1, 2, 32'h0017_0123, 32'h2, "R6 new page slot2");
    cmd(3'd1, 32'h0008_0000, ppn_of(32'h0008_0000) << 5, 0, 0, 1'b0, "R6 evict");
    look(32'h0005_0000, 0, 0, 0, 0, "R6 slot3 victim");
    cmd(3'd2, 32'h0008_0000, 32'h3, 0, 0, 1'b0, "R6 protect");
    // R4: remap a covered page clears the old translation
    cmd(3'd1, 32'h0001_2000, 32'h200 << 5, 0, 0, 1'b0, "R4 remap");
    look(32'h0001_2345, 0, 0, 0, 0, "R4 covered entry cleared");
    cmd(3'd2, 32'h0001_2000, 32'h77, 0, 0, 1'b0, "R4 protect");
    look(32'h0001_2345, 1, 7, 32'h0020_0345, 32'h77, "R4 R5 remap slot7");
    // R10: pinned block over four pages
    cmd(3'd5, 32'h0010_0000, 32'h777 << 5, 4, 1, 1'b0, "R10 pin load");
    look(32'h0010_2000, 0, 0, 0, 0, "R10 invalid after load");
    cmd(3'd2, 32'h0010_2000, 32'hB, 0, 0, 1'b0, "R10 protect");
    look(32'h0010_3ABC, 1, 1, 32'h0077_AABC, 32'hB, "R3 R10 block offset");
    look(32'h0010_4000, 0, 0, 0, 0, "R10 block end");
    look(32'h0010_0000, 1, 1, 32'h0077_7000, 32'hB, "R10 block start");
    // R2: pinned slot0 shadows slot7
    cmd(3'd5, 32'h0001_2000, 32'h55 << 5, 1, 0, 1'b0, "R10 pin slot0");
    cmd(3'd2, 32'h0001_2000, 32'hC, 0, 0, 1'b0, "R7 protect first match");
    look(32'h0001_2345, 1, 0, 32'h0005_5345, 32'hC, "R2 lowest slot wins");
    // R8
    cmd(3'd3, 32'h0001_2000, 32'h0, 0, 0, 1'b0, "R8 purge pinned");
    look(32'h0001_2345, 1, 0, 32'h0005_5345, 32'hC, "R8 pinned untouched");
    cmd(3'd3, 32'h0002_0000, 32'h0, 0, 0, 1'b0, "R8 purge page");
    look(32'h0002_0000, 0, 0, 0, 0, "R8 page gone");
    look(32'h0003_0000, 1, 5, 32'h0013_0000, 32'h1, "R8 neighbour kept");
    // R9
    cmd(3'd4, 32'h0, 32'h0, 0, 0, 1'b0, "R9 purge ordinary");
    look(32'h0010_3000, 1, 1, 32'h0077_A000, 32'hB, "R9 pinned kept");
    look(32'h0008_0000, 0, 0, 0, 0, "R9 ordinary gone");
    look(32'h0001_2345, 1, 0, 32'h0005_5345, 32'hC, "R9 pinned slot0 kept");
    // R5 R6 R9: refill, then walk pointer through wrap
    for (int k = 0; k < 6; k++) page(32'h000A_0000 + 32'(k) * 32'h1000, 32'h10, "R5 refill");
    for (int j = 0; j < 7; j++) begin
      logic [31:0] va;
      va = 32'h000B_0000 + 32'(j) * 32'h1000;
      page(va, 32'h20 + 32'(j), "R6 evict walk");
      look(va + 32'h44, 1, (j == 0 || j == 6) ? 2 : 2 + j, (ppn_of(va) << 12) + 32'h44,
           32'h20 + 32'(j), "R6 R9 victim order");
    end
    look(32'h000A_0000, 0, 0, 0, 0, "R6 slot7 evicted");
    // R11
    cmd(3'd6, 32'h0, 32'h0, 0, 0, 1'b0, "R11 pin clear");
    look(32'h0001_2345, 0, 0, 0, 0, "R11 slot0 cleared");
    cmd(3'd6, 32'h0, 32'h0, 0, 5, 1'b1, "R11 bad slot error");
    cmd(3'd5, 32'h0020_0000, 32'h1 << 5, 0, 0, 1'b1, "R10 zero length error");
    look(32'h0020_0000, 0, 0, 0, 0, "R10 rejected load has no effect");
    cmd(3'd5, 32'h0020_0000, 32'h1 << 5, 2, 6, 1'b1, "R10 bad slot error");
    look(32'h0010_3000, 1, 1, 32'h0077_A000, 32'hB, "R10 R11 rejects keep slot1");
    cmd(3'd0, 32'h0010_0000, 32'h0, 0, 0, 1'b0, "R11 nop");
    cmd(3'd7, 32'h0, 32'h0, 0, 0, 1'b0, "R11 pin clear all");
    look(32'h0010_0000, 0, 0, 0, 0, "R11 block gone");
    look(32'hFFFF_FFFF, 0, 0, 0, 0, "R12 all-ones miss after clears");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule